// File: doc/BRIEF.md
# Real-Time-Clock Indexed Register Port

This block is the host-side register file of a real-time-clock device. The host reaches it through two addresses. A write to the even address selects a register, and an access to the odd address then reads or writes the selected register. The file holds the clock's time fields, its alarm fields, two control registers, a status register, a read-only validity register, and general storage. Each register class has its own write rule.

Three other pieces of logic surround the block. The time-advance logic watches the commit and alarm-update pulses and reads the exported time vector. It also reports update progress and raises the periodic, alarm and update-ended flags through single-cycle pulses. The periodic divider takes the rate and divider fields from control register A, and the enable and mode bits from register B. The block combines the flags with their enables to form the interrupt line.

Register indices: seconds 0, seconds alarm 1, minutes 2, minutes alarm 3, hours 4, hours alarm 5, weekday 6, day of month 7, month 8, year 9, control A 10, control B 11, status C 12, validity D 13.

Top module: `rtc_port`

## Requirements
- R1: A write to the even address (`busAddr`=0) sets the current index to the written data masked to 7 bits. A read of the even address returns `{1'b0, index}`.
- R2: An odd-address write whose index is at or beyond `REG_COUNT` changes nothing and raises no pulse. An odd-address read at such an index returns 0x00.
- R3: Writes to status register C (12) and validity register D (13) have no effect. D reads 0x80 from reset.
- R4: A write to register A (10) stores bits 6:0 and leaves bit 7 (update in progress, UIP) unchanged. `rateSel` is A[3:0] and `divSel` is A[6:4].
- R5: A `uipSet` pulse sets A[7] only while B[7] (SET) is 0. A `uipDone` pulse clears A[7]. A write of B with bit 7 high clears A[7], and this takes priority over `uipSet`.
- R6: Writes to the time fields (0, 2, 4, 6, 7, 8, 9) always store the value, which appears in `timeVec` (seconds in bits 7:0, upward in index order). If SET was 0, `timeCommit` pulses in the following cycle.
- R7: A write of B that changes SET from 1 to 0 pulses `timeCommit` once in the following cycle. A write that keeps SET at 1 or sets it does not.
- R8: `irq` is the OR of (C[6] and B[6]), (C[5] and B[5]) and (C[4] and B[4]). A read of C returns `irq` in bit 7, the flags in bits 6:4, and zero in bits 3:0. When a B write enables an already-pending flag, `irq` is high from the next cycle.
- R9: Writes to the alarm fields (1, 3, 5) store the value, and `alarmUpdate` pulses in the following cycle. Time-field writes also pulse it, as do B writes that change bit 7, 2 or 1.
- R10: An odd-address read of C clears flags C[6:4] at that clock edge. A flag pulse in the same cycle as the read survives the clear.
- R11: All other in-range indices are plain storage that reads back what was written. After reset every register is 0x00 except D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access strobe, one access per cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data (combinational) |
| uipSet | input | 1 | Pulse: time update starting |
| uipDone | input | 1 | Pulse: time update finished |
| pfSet | input | 1 | Pulse: periodic flag event |
| afSet | input | 1 | Pulse: alarm flag event |
| ufSet | input | 1 | Pulse: update-ended flag event |
| irq | output | 1 | Interrupt request |
| rateSel | output | 4 | Periodic rate field of register A |
| divSel | output | 3 | Divider field of register A |
| ctrlB | output | 8 | Control register B |
| timeVec | output | 56 | Seven time fields, seconds lowest |
| timeCommit | output | 1 | Pulse: time fields to be taken as current time |
| alarmUpdate | output | 1 | Pulse: alarm comparison to be re-evaluated |

## Verification
The bench targets the read-only UIP bit under a register A write. A design that stored the whole byte would let the host fake or hide an update in progress. It checks that a read of C clears the flags while a flag pulse in the same cycle still survives, because a plain clear would drop an interrupt. It checks the SET handshake. A design that committed on every B write, or never on the falling SET edge, would either corrupt the clock or lose the host's new time. It also checks that an enable write over an already-pending flag raises `irq` at once, and that out-of-range indices leave storage untouched.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

  localparam int IDX_W = 7;

  localparam int IDX_SEC   = 0;
  localparam int IDX_SECAL = 1;
  localparam int IDX_MINAL = 3;
  localparam int IDX_HRAL  = 5;
  localparam int IDX_A     = 10;
  localparam int IDX_B     = 11;
  localparam int IDX_C     = 12;
  localparam int IDX_D     = 13;
  localparam int NUM_TIME  = 7;

  // Bits of B whose change requires alarm re-evaluation: SET, 24h, binary
  localparam logic [7:0] B_ALARM_MASK = 8'h86;

  typedef struct packed {
    logic wrStore;
    logic wrTime;
    logic wrAlarm;
    logic wrA;
    logic wrB;
    logic wrRo;
    logic rdC;
  } rtcStrobe_t;

  // Register index of time field k (seconds first)
  function automatic int timeIdx(input int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return k + 3;
    endcase
  endfunction

endpackage

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
  import rtc_port_pkg::*;
#(
  parameter int REG_COUNT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [7:0]       busWdata,
  output logic [IDX_W-1:0] regIdx,
  output logic             inRange,
  output rtcStrobe_t       strobe
);

  logic             dataWr;
  logic             isTime;
  logic             isAlarm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regIdx <= '0;
    end else if (busSel && busWr && !busAddr) begin
      regIdx <= busWdata[IDX_W-1:0];
    end
  end

  assign inRange = int'(regIdx) < REG_COUNT;
  assign dataWr  = busSel && busWr && busAddr && inRange;

  always_comb begin
    isTime = 1'b0;
    for (int k = 0; k < NUM_TIME; k++) begin
      if (int'(regIdx) == timeIdx(k)) isTime = 1'b1;
    end
  end

  assign isAlarm = (int'(regIdx) == IDX_SECAL) || (int'(regIdx) == IDX_MINAL) ||
                   (int'(regIdx) == IDX_HRAL);

  always_comb begin
    strobe = '0;
    if (dataWr) begin
      if (isTime)                                                strobe.wrTime  = 1'b1;
      else if (isAlarm)                                          strobe.wrAlarm = 1'b1;
      else if (int'(regIdx) == IDX_A)                            strobe.wrA     = 1'b1;
      else if (int'(regIdx) == IDX_B)                            strobe.wrB     = 1'b1;
      else if (int'(regIdx) == IDX_C || int'(regIdx) == IDX_D)   strobe.wrRo    = 1'b1;
      else                                                       strobe.wrStore = 1'b1;
    end
    strobe.rdC = busSel && !busWr && busAddr && (int'(regIdx) == IDX_C);
  end

  // R1: index port keeps the low seven bits of the written byte
  a_r1_index_mask: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr) |=> (regIdx == $past(busWdata[IDX_W-1:0])));

  // R2: an out-of-range data write produces no write strobe
  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr && (int'(regIdx) >= REG_COUNT)) |->
      !(strobe.wrStore || strobe.wrTime || strobe.wrAlarm || strobe.wrA || strobe.wrB));

endmodule

// File: rtl/rtc_port_regs.sv
module rtc_port_regs
  import rtc_port_pkg::*;
#(
  parameter int REG_COUNT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             inRange,
  input  rtcStrobe_t       strobe,
  input  logic [7:0]       wdata,
  input  logic             uipSet,
  input  logic             uipDone,
  input  logic             pfSet,
  input  logic             afSet,
  input  logic             ufSet,
  output logic [7:0]       rdData,
  output logic             irq,
  output logic [3:0]       rateSel,
  output logic [2:0]       divSel,
  output logic [7:0]       ctrlB,
  output logic [8*NUM_TIME-1:0] timeVec,
  output logic             timeCommit,
  output logic             alarmUpdate
);

  localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [AW-1:0] AI = AW'(IDX_A);
  localparam logic [AW-1:0] BI = AW'(IDX_B);
  localparam logic [AW-1:0] CI = AW'(IDX_C);
  localparam logic [AW-1:0] DI = AW'(IDX_D);

  logic [7:0]    regFile [REG_COUNT];
  logic [AW-1:0] addr;
  logic [2:0]    flags;
  logic [2:0]    enables;
  logic [2:0]    flagsNext;

  assign addr    = regIdx[AW-1:0];
  assign flags   = regFile[CI][6:4];
  assign enables = regFile[BI][6:4];
  assign irq     = |(flags & enables);

  assign flagsNext = (strobe.rdC ? 3'b000 : flags) | {pfSet, afSet, ufSet};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        regFile[i] <= (i == IDX_D) ? 8'h80 : 8'h00;
      end
      timeCommit  <= 1'b0;
      alarmUpdate <= 1'b0;
    end else begin
      if (strobe.wrStore || strobe.wrTime || strobe.wrAlarm) regFile[addr] <= wdata;
      if (strobe.wrA) regFile[AI] <= {regFile[AI][7], wdata[6:0]};
      if (strobe.wrB) regFile[BI] <= wdata;
      if (strobe.wrB && wdata[7])               regFile[AI][7] <= 1'b0;
      else if (uipSet && !regFile[BI][7])       regFile[AI][7] <= 1'b1;
      else if (uipDone)                         regFile[AI][7] <= 1'b0;
      regFile[CI] <= {1'b0, flagsNext, 4'b0000};
      timeCommit  <= (strobe.wrTime && !regFile[BI][7]) ||
                     (strobe.wrB && regFile[BI][7] && !wdata[7]);
      alarmUpdate <= strobe.wrAlarm || strobe.wrTime ||
                     (strobe.wrB && |((wdata ^ regFile[BI]) & B_ALARM_MASK));
    end
  end

  always_comb begin
    if (!inRange)                 rdData = 8'h00;
    else if (int'(regIdx) == IDX_C) rdData = {irq, flags, 4'b0000};
    else                          rdData = regFile[addr];
  end

  assign rateSel = regFile[AI][3:0];
  assign divSel  = regFile[AI][6:4];
  assign ctrlB   = regFile[BI];

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_time
    assign timeVec[8*k +: 8] = regFile[AW'(timeIdx(k))];
  end

  // R4: a register A write alone leaves the UIP bit as it was
  a_r4_uip_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrA && !uipSet && !uipDone) |=> (regFile[AI][7] == $past(regFile[AI][7])));

  // R5: entering set mode clears UIP whatever else happens
  a_r5_set_clears_uip: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrB && wdata[7]) |=> !regFile[AI][7]);

  // R3: the validity register never changes
  a_r3_ro_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrRo |=> $stable(regFile[DI]));

  // R7: leaving set mode commits the held time
  a_r7_commit_on_exit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrB && regFile[BI][7] && !wdata[7]) |=> timeCommit);

  // R8: enabling a pending periodic flag raises irq in the next cycle
  a_r8_pending_irq: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrB && wdata[6] && regFile[CI][6]) |=> irq);

  // R10: a read of C clears a flag unless it is set again in the same cycle
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdC && !pfSet) |=> !regFile[CI][6]);
  a_r10_set_survives: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdC && afSet) |=> regFile[CI][5]);

endmodule

// File: rtl/rtc_port.sv
module rtc_port
  import rtc_port_pkg::*;
#(
  parameter int REG_COUNT = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        uipSet,
  input  logic        uipDone,
  input  logic        pfSet,
  input  logic        afSet,
  input  logic        ufSet,
  output logic        irq,
  output logic [3:0]  rateSel,
  output logic [2:0]  divSel,
  output logic [7:0]  ctrlB,
  output logic [55:0] timeVec,
  output logic        timeCommit,
  output logic        alarmUpdate
);

  logic [IDX_W-1:0] regIdx;
  logic             inRange;
  rtcStrobe_t       strobe;
  logic [7:0]       regRdata;

  rtc_port_ctrl #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .regIdx   (regIdx),
    .inRange  (inRange),
    .strobe   (strobe)
  );

  rtc_port_regs #(.REG_COUNT(REG_COUNT)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .regIdx      (regIdx),
    .inRange     (inRange),
    .strobe      (strobe),
    .wdata       (busWdata),
    .uipSet      (uipSet),
    .uipDone     (uipDone),
    .pfSet       (pfSet),
    .afSet       (afSet),
    .ufSet       (ufSet),
    .rdData      (regRdata),
    .irq         (irq),
    .rateSel     (rateSel),
    .divSel      (divSel),
    .ctrlB       (ctrlB),
    .timeVec     (timeVec),
    .timeCommit  (timeCommit),
    .alarmUpdate (alarmUpdate)
  );

  assign busRdata = busAddr ? regRdata : {1'b0, regIdx};

endmodule

// File: tb/rtc_port_tb.sv
module rtc_port_tb;

  localparam int NREG = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 0, busWr = 0, busAddr = 0;
  logic [7:0]  busWdata = 0;
  logic [7:0]  busRdata;
  logic        uipSet = 0, uipDone = 0, pfSet = 0, afSet = 0, ufSet = 0;
  logic        irq;
  logic [3:0]  rateSel;
  logic [2:0]  divSel;
  logic [7:0]  ctrlB;
  logic [55:0] timeVec;
  logic        timeCommit, alarmUpdate;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;

  logic [7:0] mdl [NREG];
  logic [6:0] mIdx;
  logic       expCommit, expAlarm, gotCommit, gotAlarm;
  logic [7:0] rv;

  always #5 clk = ~clk;

  rtc_port #(.REG_COUNT(NREG)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .uipSet(uipSet), .uipDone(uipDone),
    .pfSet(pfSet), .afSet(afSet), .ufSet(ufSet), .irq(irq), .rateSel(rateSel),
    .divSel(divSel), .ctrlB(ctrlB), .timeVec(timeVec), .timeCommit(timeCommit),
    .alarmUpdate(alarmUpdate)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic isTimeIdx(input int i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 6) || (i == 7) || (i == 8) || (i == 9);
  endfunction

  function automatic logic expIrq();
    return |(mdl[12][6:4] & mdl[11][6:4]);
  endfunction

  // Model of a data-port write; sets the expected pulses
  function automatic void mdlWrite(input logic [7:0] d);
    int i = int'(mIdx);
    expCommit = 1'b0;
    expAlarm  = 1'b0;
    if (i >= NREG) return;
    if (isTimeIdx(i)) begin
      mdl[i] = d; expAlarm = 1'b1; expCommit = !mdl[11][7];
    end else if (i == 1 || i == 3 || i == 5) begin
      mdl[i] = d; expAlarm = 1'b1;
    end else if (i == 10) begin
      mdl[10] = {mdl[10][7], d[6:0]};
    end else if (i == 11) begin
      expCommit = mdl[11][7] && !d[7];
      expAlarm  = |((d ^ mdl[11]) & 8'h86);
      if (d[7]) mdl[10][7] = 1'b0;
      mdl[11] = d;
    end else if (i != 12 && i != 13) begin
      mdl[i] = d;
    end
  endfunction

  function automatic logic [7:0] mdlRead(input logic odd);
    int i = int'(mIdx);
    if (!odd) return {1'b0, mIdx};
    if (i >= NREG) return 8'h00;
    if (i == 12) return {expIrq(), mdl[12][6:4], 4'b0000};
    return mdl[i];
  endfunction

  task automatic wrPort(input logic a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    if (a) mdlWrite(d);
    else begin mIdx = d[6:0]; expCommit = 0; expAlarm = 0; end
    @(posedge clk);
    @(negedge clk);
    gotCommit = timeCommit; gotAlarm = alarmUpdate;
    busSel = 0; busWr = 0;
  endtask

  task automatic rdPort(input logic a, output logic [7:0] v);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 v = busRdata;
    @(posedge clk);
    if (a && int'(mIdx) == 12) mdl[12][6:4] = 3'b000;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pulse(input logic [4:0] p); // {uipSet, uipDone, pf, af, uf}
    @(negedge clk);
    {uipSet, uipDone, pfSet, afSet, ufSet} = p;
    @(posedge clk);
    @(negedge clk);
    {uipSet, uipDone, pfSet, afSet, ufSet} = '0;
    mdl[12][6:4] = mdl[12][6:4] | p[2:0];
    if (p[4] && !mdl[11][7]) mdl[10][7] = 1'b1;
    else if (p[3]) mdl[10][7] = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) mdl[i] = (i == 13) ? 8'h80 : 8'h00;
    mIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // Reset state (R11, R3)
    check("R11 reset irq", irq, 0);
    check("R11 reset rateSel", rateSel, 0);
    rdPort(1'b1, rv); check("R11 reset reg0", rv, 8'h00);
    wrPort(1'b0, 8'd13); rdPort(1'b1, rv); check("R3 D reset", rv, 8'h80);

    // R1 index mask
    wrPort(1'b0, 8'h8B); rdPort(1'b0, rv); check("R1 index mask", rv, 8'h0B);

    // R4/R5 UIP handling
    wrPort(1'b0, 8'd10);
    pulse(5'b10000); rdPort(1'b1, rv); check("R5 uipSet", rv, 8'h80);
    wrPort(1'b1, 8'h26); rdPort(1'b1, rv); check("R4 UIP kept high", rv, 8'hA6);
    check("R4 rateSel", rateSel, 4'h6);
    check("R4 divSel", divSel, 3'h2);
    pulse(5'b01000); rdPort(1'b1, rv); check("R5 uipDone", rv, 8'h26);
    wrPort(1'b1, 8'hFF); rdPort(1'b1, rv); check("R4 UIP kept low", rv, 8'h7F);
    pulse(5'b10000);
    wrPort(1'b0, 8'd11); wrPort(1'b1, 8'h80);
    check("R7 no commit on entering SET", gotCommit, 0);
    wrPort(1'b0, 8'd10); rdPort(1'b1, rv); check("R5 SET clears UIP", rv, 8'h7F);
    pulse(5'b10000); rdPort(1'b1, rv); check("R5 uipSet ignored in SET", rv, 8'h7F);

    // R6 time write in set mode: no commit
    wrPort(1'b0, 8'd9); wrPort(1'b1, 8'h24);
    check("R6 set-mode write no commit", gotCommit, 0);
    check("R6 timeVec year", timeVec[55:48], 8'h24);
    wrPort(1'b0, 8'd11); wrPort(1'b1, 8'h00);
    check("R7 commit on leaving SET", gotCommit, 1);
    check("R9 alarm update on SET change", gotAlarm, 1);
    wrPort(1'b1, 8'h00); check("R7 no commit on repeat write", gotCommit, 0);
    wrPort(1'b0, 8'd0); wrPort(1'b1, 8'h59);
    check("R6 commit outside set mode", gotCommit, 1);
    check("R6 timeVec seconds", timeVec[7:0], 8'h59);

    // R9 alarm
    wrPort(1'b0, 8'd3); wrPort(1'b1, 8'h45);
    check("R9 alarm pulse", gotAlarm, 1);
    check("R9 alarm no commit", gotCommit, 0);
    rdPort(1'b1, rv); check("R9 alarm stored", rv, 8'h45);

    // R3 read-only registers
    wrPort(1'b0, 8'd12); wrPort(1'b1, 8'hFF); rdPort(1'b1, rv); check("R3 C write ignored", rv, 8'h00);
    wrPort(1'b0, 8'd13); wrPort(1'b1, 8'h00); rdPort(1'b1, rv); check("R3 D write ignored", rv, 8'h80);

    // R8 / R10 flags and interrupt
    pulse(5'b00100); check("R8 flag without enable", irq, 0);
    wrPort(1'b0, 8'd12); rdPort(1'b1, rv); check("R8 C read pf", rv, 8'h40);
    rdPort(1'b1, rv); check("R10 C cleared by read", rv, 8'h00);
    pulse(5'b00010);
    wrPort(1'b0, 8'd11); wrPort(1'b1, 8'h20);
    check("R8 pending flag raises irq", irq, 1);
    wrPort(1'b0, 8'd12); rdPort(1'b1, rv); check("R8 C read with irq", rv, 8'hA0);
    check("R10 irq drops after read", irq, 0);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 1; afSet = 1;
    @(posedge clk);
    @(negedge clk);
    busSel = 0; afSet = 0; mdl[12][6:4] = 3'b010;
    check("R10 same-cycle flag survives", irq, 1);
    rdPort(1'b1, rv); check("R10 surviving flag read", rv, 8'hA0);

    // R2 out-of-range index
    wrPort(1'b0, 8'd20); wrPort(1'b1, 8'h5A);
    wrPort(1'b0, 8'h54); wrPort(1'b1, 8'h33);
    check("R2 no pulse", {gotCommit, gotAlarm}, 0);
    rdPort(1'b1, rv); check("R2 read out of range", rv, 8'h00);
    wrPort(1'b0, 8'd20); rdPort(1'b1, rv); check("R11 storage untouched by R2 write", rv, 8'h5A);

    // Constrained random mix (R1, R4, R6, R7, R8, R9, R10, R11)
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 3) begin
        logic [7:0] ix;
        ix = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
        wrPort(1'b0, ix);
      end else if (op < 6) begin
        logic [7:0] d = 8'($urandom);
        wrPort(1'b1, d);
        check("R6/R7 random commit", gotCommit, expCommit);
        check("R9 random alarm pulse", gotAlarm, expAlarm);
      end else if (op < 8) begin
        logic [7:0] e;
        logic odd = 1'($urandom);
        e = mdlRead(odd);
        rdPort(odd, rv);
        check("R11 random read", rv, e);
      end else begin
        pulse({2'b00, 3'($urandom)});
      end
      check("R8 random irq", irq, expIrq());
    end

    finishRun();
  end

endmodule